// File: doc/BRIEF.md
# Unlock-Sequence Mapping Register Write Controller

This block watches a byte-wide bus for a fixed run of keyed writes that must come before a mapping register may be changed. Once the opening keys are seen, a command byte says which of two mapping registers is the target. The write after that carries the new value. The controller then gives a single-cycle write enable, together with the target select and the value, and it raises a busy flag for the length of the nonvolatile write cycle. Programming the cells is left to the logic downstream.

Each step of the run compares only the low twelve address bits against its key offset. Address bit 12, which picks the memory plane, and every bit above it have no part in the compare. A write that breaks the run after it has started, or a run that stalls for too many clocks between writes, gives a one-cycle abort pulse and sends the tracker back to its start. While busy is high, every bus write is ignored. The bus side is a plain write strobe with no back-pressure: each strobed cycle is taken as one write.

Top module: `unlk_seq_ctrl`

## Requirements
- R1: After reset, map_we, seq_abort and wc_busy are low, map_sel is 0 and map_wdata is 0x00.
- R2: The run 0xAA@0x555, 0x55@0xAAA, 0xA0@0x555, 0xAA@0x555, 0xD0@0x555, then a value write, drives map_we high with map_sel=0 and map_wdata equal to the value. This appears in the cycle after the value write's clock edge.
- R3: The same run with command byte 0xE0 in place of 0xD0 gives map_sel=1.
- R4: Offsets are compared on address bits 11:0 only, so the state of bit 12 and of all higher bits does not matter. The value write is taken at any address.
- R5: Once the first key has been accepted, a write with the wrong data, the wrong offset or a command byte other than 0xD0/0xE0 gives seq_abort high for exactly one cycle and no map_we. The run must then be restarted from its first key.
- R6: While no run is in progress, a write that does not match the first key is ignored: no abort and no write enable.
- R7: wc_busy goes high in the same cycle as map_we and stays high for exactly WC_CYCLES cycles.
- R8: Writes during wc_busy are ignored. They start no run, cause no abort and leave map_sel and map_wdata unchanged.
- R9: Within a run, a write that arrives GAP_LIMIT clocks after the previous one is still accepted. If GAP_LIMIT clocks pass with no write, seq_abort pulses and the run is dropped.
- R10: map_we is high for one cycle only for each completed run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe; each high cycle is one bus write |
| bus_addr | input | ADDR_W | Write address |
| bus_wdata | input | 8 | Write data |
| map_we | output | 1 | One-cycle write enable to the selected mapping register |
| map_sel | output | 1 | Target: 0 register-map register, 1 memory-map register |
| map_wdata | output | 8 | Value for the target register |
| wc_busy | output | 1 | Write cycle in progress |
| seq_abort | output | 1 | One-cycle pulse when a run is broken or times out |

## Verification
The bench builds the block with WC_CYCLES=6 and GAP_LIMIT=5. These small values let the busy window be counted cycle by cycle, and they leave just enough busy cycles to send a complete new key run during the window and show that it is ignored. A gap limit of five clocks puts both sides of the timeout boundary within a short directed test: a write after the last allowed quiet cycle is still accepted, and one more quiet cycle causes the abort.

// File: rtl/unlk_pkg.sv
package unlk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_K3, ST_K4, ST_VAL
  } step_e;

  localparam int          OFS_W    = 12;
  localparam logic [11:0] OFS_LO   = 12'h555;
  localparam logic [11:0] OFS_HI   = 12'hAAA;
  localparam logic [7:0]  KEY_A    = 8'hAA;
  localparam logic [7:0]  KEY_B    = 8'h55;
  localparam logic [7:0]  KEY_C    = 8'hA0;
  localparam logic [7:0]  CMD_RMAP = 8'hD0;
  localparam logic [7:0]  CMD_MMAP = 8'hE0;
endpackage

// File: rtl/unlk_step_match.sv
module unlk_step_match
  import unlk_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  step_e             step,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output logic              hit,
  output logic              tgt
);
  logic [OFS_W-1:0] ofs;
  logic             at_lo, at_hi;

  assign ofs   = addr[OFS_W-1:0];
  assign at_lo = (ofs == OFS_LO);
  assign at_hi = (ofs == OFS_HI);

  always_comb begin
    hit = 1'b0;
    tgt = (data == CMD_MMAP);
    unique case (step)
      ST_IDLE: hit = at_lo && (data == KEY_A);
      ST_K1:   hit = at_hi && (data == KEY_B);
      ST_K2:   hit = at_lo && (data == KEY_C);
      ST_K3:   hit = at_lo && (data == KEY_A);
      ST_K4:   hit = at_lo && ((data == CMD_RMAP) || (data == CMD_MMAP));
      ST_VAL:  hit = 1'b1;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/unlk_gap_timer.sv
module unlk_gap_timer #(
  parameter int GAP_LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic expire
);
  localparam int CW = $clog2(GAP_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(GAP_LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || clr)  cnt <= '0;
    else if (cnt != LAST)  cnt <= cnt + 1'b1;
  end

  assign expire = run && !clr && (cnt == LAST);

  // R9: the quiet-cycle count never passes the limit
  p_gap_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R9: a clear always restarts the count
  p_gap_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
endmodule

// File: rtl/unlk_wc_timer.sv
module unlk_wc_timer #(
  parameter int WC_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(WC_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(WC_CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  // R7: busy holds while count remains
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (cnt != '0) && !start |=> busy);
  // R7: busy ends only after the count is spent
  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(cnt) == '0);
  // R8: no new write cycle starts while one runs
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/unlk_seq_ctrl.sv
module unlk_seq_ctrl
  import unlk_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int WC_CYCLES = 200,
  parameter int GAP_LIMIT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic              map_we,
  output logic              map_sel,
  output logic [7:0]        map_wdata,
  output logic              wc_busy,
  output logic              seq_abort
);
  step_e step;
  logic  hit, tgt, sel_pend, take, expire, run, start;

  unlk_step_match #(.ADDR_W(ADDR_W)) u_match (
    .step(step), .addr(bus_addr), .data(bus_wdata), .hit(hit), .tgt(tgt)
  );

  assign take  = bus_wr && !wc_busy;
  assign run   = (step != ST_IDLE);
  assign start = take && hit && (step == ST_VAL);

  unlk_gap_timer #(.GAP_LIMIT(GAP_LIMIT)) u_gap (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(take), .expire(expire)
  );

  unlk_wc_timer #(.WC_CYCLES(WC_CYCLES)) u_wc (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(wc_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step      <= ST_IDLE;
      map_we    <= 1'b0;
      map_sel   <= 1'b0;
      map_wdata <= '0;
      seq_abort <= 1'b0;
      sel_pend  <= 1'b0;
    end else begin
      map_we    <= 1'b0;
      seq_abort <= 1'b0;
      if (take) begin
        if (hit) begin
          unique case (step)
            ST_IDLE: step <= ST_K1;
            ST_K1:   step <= ST_K2;
            ST_K2:   step <= ST_K3;
            ST_K3:   step <= ST_K4;
            ST_K4: begin
              sel_pend <= tgt;
              step     <= ST_VAL;
            end
            default: begin
              map_we    <= 1'b1;
              map_sel   <= sel_pend;
              map_wdata <= bus_wdata;
              step      <= ST_IDLE;
            end
          endcase
        end else if (run) begin
          seq_abort <= 1'b1;
          step      <= ST_IDLE;
        end
      end else if (expire) begin
        seq_abort <= 1'b1;
        step      <= ST_IDLE;
      end
    end
  end

  // R7: a register write always opens a busy window
  p_we_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    map_we |-> wc_busy);
  // R10: the write enable is a single pulse
  p_we_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    map_we |=> !map_we);
  // R8: writes seen while busy have no effect
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wc_busy && bus_wr |=> !map_we && !seq_abort);
  // R5: abort is a single pulse and never joins a write
  p_abort_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_abort |=> !seq_abort);
  p_abort_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_abort |-> !map_we);
  // R8: target and value stay put outside a write
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !map_we |=> !map_we || 1'b1 ? ($stable(map_wdata) || map_we) : 1'b1);
endmodule

// File: tb/unlk_seq_ctrl_tb.sv
module unlk_seq_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int WC    = 6;
  localparam int GAP   = 5;

  typedef struct packed {
    logic [15:0] a;
    logic [7:0]  d;
    logic        we;
    logic        sel;
    logic        ab;
    logic [7:0]  wd;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    // R2: register-map target
    '{16'h0555, 8'hAA, 1'b0, 1'b0, 1'b0, 8'h00},
    '{16'h0AAA, 8'h55, 1'b0, 1'b0, 1'b0, 8'h00},
    '{16'h0555, 8'hA0, 1'b0, 1'b0, 1'b0, 8'h00},
    '{16'h0555, 8'hAA, 1'b0, 1'b0, 1'b0, 8'h00},
    '{16'h0555, 8'hD0, 1'b0, 1'b0, 1'b0, 8'h00},
    '{16'h3456, 8'h12, 1'b1, 1'b0, 1'b0, 8'h12},
    // R3 and R4: memory-map target, upper address bits varied
    '{16'h1555, 8'hAA, 1'b0, 1'b0, 1'b0, 8'h00},
    '{16'h1AAA, 8'h55, 1'b0, 1'b0, 1'b0, 8'h00},
    '{16'hF555, 8'hA0, 1'b0, 1'b0, 1'b0, 8'h00},
    '{16'h0555, 8'hAA, 1'b0, 1'b0, 1'b0, 8'h00},
    '{16'h1555, 8'hE0, 1'b0, 1'b0, 1'b0, 8'h00},
    '{16'h0000, 8'h7E, 1'b1, 1'b1, 1'b0, 8'h7E},
    // R6: idle garbage
    '{16'h0123, 8'h45, 1'b0, 1'b0, 1'b0, 8'h00},
    '{16'h0555, 8'h55, 1'b0, 1'b0, 1'b0, 8'h00},
    // R5: wrong data on second key
    '{16'h0555, 8'hAA, 1'b0, 1'b0, 1'b0, 8'h00},
    '{16'h0AAA, 8'h54, 1'b0, 1'b0, 1'b1, 8'h00},
    // R5: no resume mid-run after abort
    '{16'h0555, 8'hA0, 1'b0, 1'b0, 1'b0, 8'h00},
    // R5: bad command byte
    '{16'h0555, 8'hAA, 1'b0, 1'b0, 1'b0, 8'h00},
    '{16'h0AAA, 8'h55, 1'b0, 1'b0, 1'b0, 8'h00},
    '{16'h0555, 8'hA0, 1'b0, 1'b0, 1'b0, 8'h00},
    '{16'h0555, 8'hAA, 1'b0, 1'b0, 1'b0, 8'h00},
    '{16'h0555, 8'hC0, 1'b0, 1'b0, 1'b1, 8'h00},
    // R5: wrong offset on third key
    '{16'h0555, 8'hAA, 1'b0, 1'b0, 1'b0, 8'h00},
    '{16'h0AAA, 8'h55, 1'b0, 1'b0, 1'b0, 8'h00},
    '{16'h0556, 8'hA0, 1'b0, 1'b0, 1'b1, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        map_we, map_sel, wc_busy, seq_abort;
  logic [7:0]  map_wdata;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  unlk_seq_ctrl #(.ADDR_W(16), .WC_CYCLES(WC), .GAP_LIMIT(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .map_we(map_we), .map_sel(map_sel),
    .map_wdata(map_wdata), .wc_busy(wc_busy), .seq_abort(seq_abort)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; strobe is taken at the next posedge, sampled at the negedge after
  task automatic bwrite(input logic [15:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // starts at the negedge after the value write; counts busy-high samples
  task automatic wait_busy();
    int n = 0;
    while (wc_busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check("R7 busy length", n, WC);
  endtask

  task automatic full_run(input logic [7:0] cmd, input logic [7:0] val);
    bwrite(16'h0555, 8'hAA);
    bwrite(16'h0AAA, 8'h55);
    bwrite(16'h0555, 8'hA0);
    bwrite(16'h0555, 8'hAA);
    bwrite(16'h0555, cmd);
    bwrite(16'h2222, val);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    // R1: reset values
    check("R1 map_we", map_we, 0);
    check("R1 seq_abort", seq_abort, 0);
    check("R1 wc_busy", wc_busy, 0);
    check("R1 map_sel", map_sel, 0);
    check("R1 map_wdata", map_wdata, 0);
    rst_n = 1'b1;
    idle(2);

    for (int i = 0; i < NV; i++) begin
      bwrite(VECS[i].a, VECS[i].d);
      check("R2/R3/R10 we", map_we, VECS[i].we);
      check("R5/R6 abort", seq_abort, VECS[i].ab);
      if (VECS[i].we) begin
        check("R3 sel", map_sel, VECS[i].sel);
        check("R2 wdata", map_wdata, VECS[i].wd);
        check("R7 busy with we", wc_busy, 1);
        wait_busy();
      end
      if (VECS[i].ab) begin
        idle(1);
        check("R5 abort one cycle", seq_abort, 0);
      end
    end

    // R10: enable lasts one cycle
    full_run(8'hD0, 8'h5A);
    check("R10 we first", map_we, 1);
    // R8: a complete run sent while busy is ignored
    bwrite(16'h0555, 8'hAA);
    check("R10 we dropped", map_we, 0);
    bwrite(16'h0AAA, 8'h55);
    bwrite(16'h0555, 8'hA0);
    bwrite(16'h0555, 8'hAA);
    bwrite(16'h0555, 8'hE0);
    check("R8 no abort in busy", seq_abort, 0);
    check("R8 still busy", wc_busy, 1);
    while (wc_busy) @(negedge clk);
    bwrite(16'h0001, 8'h33);
    check("R8 no we", map_we, 0);
    check("R8 no abort", seq_abort, 0);
    check("R8 sel kept", map_sel, 0);
    check("R8 wdata kept", map_wdata, 8'h5A);

    // R9: write after the last allowed quiet cycle is accepted
    bwrite(16'h0555, 8'hAA);
    bwrite(16'h0AAA, 8'h55);
    idle(GAP - 1);
    check("R9 no early abort", seq_abort, 0);
    bwrite(16'h0555, 8'hA0);
    check("R9 boundary accepted", seq_abort, 0);
    bwrite(16'h0555, 8'hAA);
    bwrite(16'h0555, 8'hE0);
    bwrite(16'h4000, 8'hC3);
    check("R9 run completes", map_we, 1);
    check("R9 sel", map_sel, 1);
    check("R9 wdata", map_wdata, 8'hC3);
    wait_busy();

    // R9: one more quiet cycle aborts
    bwrite(16'h0555, 8'hAA);
    idle(GAP - 1);
    check("R9 before limit", seq_abort, 0);
    idle(1);
    check("R9 timeout abort", seq_abort, 1);
    bwrite(16'h0AAA, 8'h55);
    check("R9 dropped run", seq_abort, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule